// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit virtual address into a 36-bit physical address by walking an in-memory page table tree. A request carries a virtual address and a write flag. The walker first reads a root entry chosen by the current context number. It then descends through up to three levels of tables, using one word-wide memory port with a request/ready handshake. A walk can stop at the first, second or third level, which maps a 16 MB, 256 KB or 4 KB page. The walker returns the physical address and the final page entry, or an error code. When translation is disabled, the address passes straight through and no memory is touched.

The walker keeps the referenced and modified bits of the final entry up to date itself. It writes the entry back to the word it came from whenever a bit must change. It handles one request at a time. The response is a single-cycle pulse, and a new request is accepted in the cycle after it.

Top module: `pt_walker`

## Requirements
- R1: With `xlat_en` low, an accepted request answers on the next cycle with `rsp_pa` = {4'b0, va}, `rsp_err` = 0 and `rsp_pte` = 0, and with no memory access.
- R2: With `xlat_en` high, the first memory read goes to address (root_ptr << 4) + (ctx_id << 4).
- R3: Bits [1:0] of every fetched entry give its type: 0 invalid, 1 table descriptor, 2 page entry, 3 reserved. A descriptor leads to the next read at ((entry & ~3) << 4) plus an index. That index is va[31:24]*4 after the root, va[23:18]*4 after the first level and va[17:12]*4 after the second level.
- R4: A page entry at the first, second or third level gives `rsp_pa` = ({entry[31:8], 12'b0}) + offset, where the offset is va[23:0], va[17:0] or va[11:0] respectively. `rsp_err` = 0 and `rsp_pte` carries the entry as it stands after any update.
- R5: An invalid entry at any level ends the walk with `rsp_err` = 1 and `rsp_pa` = 0.
- R6: A page entry at the root, a reserved entry at any level, or a descriptor at the third level ends the walk with `rsp_err` = 2 and `rsp_pa` = 0.
- R7: If the referenced bit (bit 5) of the final page entry is clear, the walker writes the entry back to its own address with bit 5 set. On a read, bit 6 is left unchanged.
- R8: On a write request whose final page entry has the modified bit (bit 6) clear, the written-back entry has both bit 5 and bit 6 set.
- R9: When no bit needs to change (bit 5 set, and for writes bit 6 set too), no memory write takes place.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady.
- R11: `req_ready` is low from acceptance until the response. `rsp_valid` is high for exactly one cycle and is followed by `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_en | input | 1 | Translation enable; low selects pass-through |
| root_ptr | input | 32 | Context table pointer (shifted left by 4) |
| ctx_id | input | CTX_W | Current context number |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_va | input | 32 | Virtual address |
| req_write | input | 1 | Request is a store |
| rsp_valid | output | 1 | Result pulse |
| rsp_err | output | 2 | 0 ok, 1 invalid address, 2 translation error |
| rsp_pa | output | 36 | Physical address (0 on error) |
| rsp_pte | output | 32 | Final entry (updated), raw entry on error |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 36 | Word address in bytes |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access completes this cycle; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The fetch of a final page entry and the decision whether to write it back fall in the same cycle. In that cycle the type decode, the bit update and the choice between the writeback state and the done state are all made from the word that `mem_ready` presents. The bench places page entries with every useful combination of referenced and modified bits under read and write requests. It judges each case by the returned entry, the word left in its memory model and the count of writes it saw. The same walks are repeated with a slow memory, to show that the held request and the decision do not depend on the memory's latency.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlat_en,
  input  logic [31:0]       root_ptr,
  input  logic [CTX_W-1:0]  ctx_id,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_va,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [1:0]        rsp_err,
  output logic [35:0]       rsp_pa,
  output logic [31:0]       rsp_pte,
  output logic              mem_req,
  output logic              mem_we,
  output logic [35:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata
);
  localparam int PA_W = 36;
  localparam logic [1:0] E_OK = 2'd0, E_INV = 2'd1, E_XLT = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_ROOT, S_L1, S_L2, S_L3, S_WB, S_DONE} st_t;

  st_t              st;
  logic [31:0]      va_q, pte_q;
  logic             wr_q;
  logic [PA_W-1:0]  addr_q;
  logic [1:0]       lvl_q, err_q;

  logic             walking, need_wb;
  logic [1:0]       etype, lvl_here;
  logic [PA_W-1:0]  base_nxt, idx;
  logic [31:0]      upd;

  assign walking  = (st == S_ROOT) || (st == S_L1) || (st == S_L2) || (st == S_L3);
  assign etype    = mem_rdata[1:0];
  assign base_nxt = {mem_rdata[31:2], 6'b0};
  assign need_wb  = !mem_rdata[5] || (wr_q && !mem_rdata[6]);
  assign upd      = mem_rdata | 32'h20 | (wr_q ? 32'h40 : 32'h0);

  always_comb begin
    idx      = '0;
    lvl_here = 2'd0;
    case (st)
      S_ROOT: idx = {26'b0, va_q[31:24], 2'b0};
      S_L1:   begin idx = {28'b0, va_q[23:18], 2'b0}; lvl_here = 2'd1; end
      S_L2:   begin idx = {28'b0, va_q[17:12], 2'b0}; lvl_here = 2'd2; end
      S_L3:   lvl_here = 2'd3;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      va_q   <= '0;
      wr_q   <= 1'b0;
      pte_q  <= '0;
      addr_q <= '0;
      lvl_q  <= '0;
      err_q  <= E_OK;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q  <= req_va;
          wr_q  <= req_write;
          pte_q <= '0;
          err_q <= E_OK;
          lvl_q <= 2'd0;
          if (!xlat_en) st <= S_DONE;
          else begin
            addr_q <= (PA_W'(root_ptr) << 4) + (PA_W'(ctx_id) << 4);
            st     <= S_ROOT;
          end
        end
        S_ROOT, S_L1, S_L2, S_L3: if (mem_ready) begin
          case (etype)
            2'd1: if (st == S_L3) begin
              err_q <= E_XLT; pte_q <= mem_rdata; st <= S_DONE;
            end else begin
              addr_q <= base_nxt + idx;
              st     <= (st == S_ROOT) ? S_L1 : (st == S_L1) ? S_L2 : S_L3;
            end
            2'd2: if (st == S_ROOT) begin
              err_q <= E_XLT; pte_q <= mem_rdata; st <= S_DONE;
            end else begin
              pte_q <= upd;
              lvl_q <= lvl_here;
              st    <= need_wb ? S_WB : S_DONE;
            end
            2'd0: begin err_q <= E_INV; pte_q <= mem_rdata; st <= S_DONE; end
            default: begin err_q <= E_XLT; pte_q <= mem_rdata; st <= S_DONE; end
          endcase
        end
        S_WB:   if (mem_ready) st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_DONE);
  assign rsp_err   = err_q;
  assign rsp_pte   = pte_q;
  assign mem_req   = walking || (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = addr_q;
  assign mem_wdata = pte_q;

  always_comb begin
    if (err_q != E_OK) rsp_pa = '0;
    else case (lvl_q)
      2'd1:    rsp_pa = {pte_q[31:8], 12'b0} + {12'b0, va_q[23:0]};
      2'd2:    rsp_pa = {pte_q[31:8], 12'b0} + {18'b0, va_q[17:0]};
      2'd3:    rsp_pa = {pte_q[31:8], 12'b0} + {24'b0, va_q[11:0]};
      default: rsp_pa = {4'b0, va_q};
    endcase
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int CTX_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xlat_en,
  input logic [31:0]       root_ptr,
  input logic [CTX_W-1:0]  ctx_id,
  input logic              req_valid,
  input logic              req_ready,
  input logic [31:0]       req_va,
  input logic              rsp_valid,
  input logic [1:0]        rsp_err,
  input logic [35:0]       rsp_pa,
  input logic              mem_req,
  input logic              mem_we,
  input logic [35:0]       mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ready
);
  localparam int PA_W = 36;

  p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !xlat_en) |=>
      (rsp_valid && rsp_err == 2'd0 && rsp_pa == {4'b0, $past(req_va)} && !mem_req));

  p_root_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && xlat_en) |=>
      (mem_req && !mem_we &&
       mem_addr == (PA_W'($past(root_ptr)) << 4) + (PA_W'($past(ctx_id)) << 4)));

  p_err_pa_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err != 2'd0) |-> (rsp_pa == '0));

  p_wb_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[5]);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=>
      (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);
endmodule

bind pt_walker pt_walker_chk #(.CTX_W(CTX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .root_ptr(root_ptr), .ctx_id(ctx_id),
  .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_pa(rsp_pa),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ready(mem_ready)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        xlat_en = 1'b0;
  logic [31:0] root_ptr = 32'h100;
  logic [7:0]  ctx_id = 8'd2;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ready, rsp_valid;
  logic [1:0]  rsp_err;
  logic [35:0] rsp_pa, mem_addr;
  logic [31:0] rsp_pte, mem_wdata, mem_rdata;
  logic        mem_req, mem_we;
  logic        mem_ready = 1'b0;

  logic [31:0] mem [0:4095];
  int          lat = 0, wcnt = 0, n_wr = 0, n_acc = 0, viol = 0;
  int          checks = 0, fails = 0;
  logic        pv = 1'b0;
  logic [35:0] pa_prev = '0;

  logic [35:0] o_pa;
  logic [31:0] o_pte;
  logic [1:0]  o_err;
  logic        o_busy_ok;

  always #4 clk = ~clk;

  pt_walker #(.CTX_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .root_ptr(root_ptr), .ctx_id(ctx_id),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_pa(rsp_pa), .rsp_pte(rsp_pte),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[13:2]];

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      n_acc <= n_acc + 1;
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        n_wr <= n_wr + 1;
      end
    end
    if (mem_req && !mem_ready) begin
      if (wcnt >= lat) begin mem_ready <= 1'b1; wcnt <= 0; end
      else wcnt <= wcnt + 1;
    end else mem_ready <= 1'b0;
  end

  always @(negedge clk) begin
    if (pv && (!mem_req || mem_addr != pa_prev)) viol = viol + 1;
    pv = mem_req && !mem_ready;
    pa_prev = mem_addr;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] exp_pa(input logic [31:0] pte, input logic [31:0] va, input int obits);
    logic [35:0] off;
    off = {4'b0, va} & ((36'd1 << obits) - 36'd1);
    return ({4'b0, pte} & 36'hFFFFFFF00) * 36'd16 + off;
  endfunction

  task automatic translate(input logic [31:0] va, input logic wr);
    int guard = 0;
    o_busy_ok = 1'b1;
    @(negedge clk);
    req_va = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && guard < 200) begin
      if (req_ready) o_busy_ok = 1'b0;
      @(negedge clk);
      guard++;
    end
    o_pa = rsp_pa; o_pte = rsp_pte; o_err = rsp_err;
  endtask

  function automatic logic [31:0] va_of(input logic [7:0] a, input logic [5:0] b, input logic [5:0] c, input logic [11:0] o);
    return {a, b, c, o};
  endfunction

  task automatic load_tables();
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem['h1020 >> 2] = 32'h0000_0201;
    mem['h1030 >> 2] = 32'h0000_0301;
    mem['h1040 >> 2] = 32'h0;
    mem['h1050 >> 2] = 32'h0000_0122;
    mem['h1060 >> 2] = 32'h0000_0203;
    mem['h2048 >> 2] = 32'h1234_5662;
    mem['h2100 >> 2] = 32'h0000_0281;
    mem['h2140 >> 2] = 32'h0000_0003;
    mem['h2180 >> 2] = 32'h0;
    mem['h2814 >> 2] = 32'h0ABC_DE02;
    mem['h2818 >> 2] = 32'h0000_02C1;
    mem['h281C >> 2] = 32'h0;
    mem['h2C24 >> 2] = 32'h7777_7722;
    mem['h2C28 >> 2] = 32'h5555_5562;
    mem['h2C30 >> 2] = 32'h0000_0101;
    mem['h3048 >> 2] = 32'h9999_9962;
  endtask

  task automatic t_reset();
    check("R11 reset req_ready", req_ready, 1);
    check("R11 reset rsp_valid", rsp_valid, 0);
    check("R10 reset mem_req", mem_req, 0);
  endtask

  task automatic t_bypass();
    int a0;
    xlat_en = 1'b0; a0 = n_acc;
    translate(32'hDEAD_BEEF, 1'b1);
    check("R1 bypass pa", o_pa, 36'h0_DEAD_BEEF);
    check("R1 bypass err", o_err, 0);
    check("R1 bypass pte", o_pte, 0);
    check("R1 bypass no memory access", n_acc - a0, 0);
    xlat_en = 1'b1;
  endtask

  task automatic t_big_page();
    int a0, w0;
    ctx_id = 8'd2; a0 = n_acc; w0 = n_wr;
    translate(32'h12AB_CDEF, 1'b0);
    check("R4 16MB pa", o_pa, exp_pa(32'h1234_5662, 32'h12AB_CDEF, 24));
    check("R4 16MB pte", o_pte, 32'h1234_5662);
    check("R2 root then L1 reads", n_acc - a0, 2);
    check("R9 16MB no writeback", n_wr - w0, 0);
  endtask

  task automatic t_context();
    ctx_id = 8'd3;
    translate(32'h12AB_CDEF, 1'b0);
    check("R2 ctx selects root", o_pa, exp_pa(32'h9999_9962, 32'h12AB_CDEF, 24));
    ctx_id = 8'd2;
  endtask

  task automatic t_mid_ref();
    int w0;
    logic [31:0] va;
    va = va_of(8'h40, 6'h05, 6'h2A, 12'hBCD); w0 = n_wr;
    translate(va, 1'b0);
    check("R3 256KB err", o_err, 0);
    check("R4 256KB pa", o_pa, exp_pa(32'h0ABC_DE22, va, 18));
    check("R7 256KB pte ref set", o_pte, 32'h0ABC_DE22);
    check("R7 256KB memory updated", mem['h2814 >> 2], 32'h0ABC_DE22);
    check("R7 one write", n_wr - w0, 1);
  endtask

  task automatic t_small_dirty();
    int w0;
    logic [31:0] va;
    va = va_of(8'h40, 6'h06, 6'h09, 12'hABC); w0 = n_wr;
    translate(va, 1'b1);
    check("R4 4KB pa", o_pa, exp_pa(32'h7777_7762, va, 12));
    check("R8 4KB pte ref+mod", o_pte, 32'h7777_7762);
    check("R8 4KB memory updated", mem['h2C24 >> 2], 32'h7777_7762);
    check("R8 one write", n_wr - w0, 1);
  endtask

  task automatic t_small_clean();
    int w0;
    logic [31:0] va;
    va = va_of(8'h40, 6'h06, 6'h0A, 12'h123); w0 = n_wr;
    translate(va, 1'b0);
    check("R9 clean read pte", o_pte, 32'h5555_5562);
    translate(va, 1'b1);
    check("R9 clean write pa", o_pa, exp_pa(32'h5555_5562, va, 12));
    check("R9 no writes", n_wr - w0, 0);
    check("R9 memory untouched", mem['h2C28 >> 2], 32'h5555_5562);
  endtask

  task automatic t_invalid();
    ctx_id = 8'd4;
    translate(32'h1200_0000, 1'b0);
    check("R5 invalid root err", o_err, 1);
    check("R5 invalid root pa", o_pa, 0);
    ctx_id = 8'd2;
    translate(32'h6000_0000, 1'b0);
    check("R5 invalid L1 err", o_err, 1);
    translate(va_of(8'h40, 6'h07, 6'h00, 12'h0), 1'b0);
    check("R5 invalid L2 err", o_err, 1);
  endtask

  task automatic t_xlat_err();
    ctx_id = 8'd5;
    translate(32'h1200_0000, 1'b0);
    check("R6 page at root", o_err, 2);
    ctx_id = 8'd6;
    translate(32'h1200_0000, 1'b0);
    check("R6 reserved at root", o_err, 2);
    ctx_id = 8'd2;
    translate(32'h5000_0000, 1'b0);
    check("R6 reserved at L1", o_err, 2);
    translate(va_of(8'h40, 6'h06, 6'h0C, 12'h0), 1'b0);
    check("R6 descriptor at L3 err", o_err, 2);
    check("R6 descriptor at L3 pa", o_pa, 0);
  endtask

  task automatic t_slow_mem();
    logic [31:0] va;
    lat = 5;
    mem['h2C24 >> 2] = 32'h7777_7702;
    va = va_of(8'h40, 6'h06, 6'h09, 12'h0F0);
    translate(va, 1'b1);
    check("R10 slow pa", o_pa, exp_pa(32'h7777_7762, va, 12));
    check("R10 slow writeback", mem['h2C24 >> 2], 32'h7777_7762);
    check("R10 request held steady", viol, 0);
    lat = 0;
  endtask

  task automatic t_busy();
    translate(32'h12AB_CDEF, 1'b0);
    check("R11 req_ready low during walk", o_busy_ok, 1);
    @(negedge clk);
    check("R11 rsp_valid one cycle", rsp_valid, 0);
    check("R11 ready after response", req_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    load_tables();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_big_page();
    t_context();
    t_mid_ref();
    t_small_dirty();
    t_small_clean();
    t_invalid();
    t_xlat_err();
    t_slow_mem();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule